// File: doc/BRIEF.md
# Dual-Byte Registered Bus Transceiver

This block moves data between two 16-bit ports, A and B, through registers. The width is split into byte sections that work on their own. Each section has one register for each direction. The A-to-B register captures the A-side input and drives the B port. The B-to-A register captures the B-side input and drives the A port. Each register has three controls: a transfer strobe, an active-low capture enable and an active-low output enable. To get full 16-bit behaviour, tie the control bits of all sections together.

The core runs on a single system clock. A transfer strobe takes effect on its low-to-high transition, which the block detects at a system clock edge. No port is tri-stated. Each port has an input bus, an output bus, a drive-enable bit per section, and a per-section input that tells the block when an outside agent drives that section. When a section's port is released, its output bus shows the level a keeper holds. That level comes either from the last value the block drove or from the last value the outside agent drove. The parameter HOLD_EN turns the keeper on or off. The block also raises a per-section contention flag when both the block and an outside agent drive the same lines.

Top module: `dbx_transceiver`

## Requirements
- R1: When a section's A-to-B strobe is low at one system clock edge and high at the next, and that section's A-to-B capture enable (active low) is 0, the section's A-to-B register takes that section's slice of a_in at that edge.
- R2: When the capture enable of a direction is 1, a strobe rise leaves that register unchanged.
- R3: A strobe held high over several edges captures only once. Data that changes while the strobe stays high is not taken.
- R4: A section's drive-enable output for a port is 1 exactly when that port's output enable (active low) is 0. While it is 1, the port's output slice equals the register of the direction that drives that port.
- R5: The output enable never alters a register. A capture made while the port is released appears on the port once driving is enabled.
- R6: B-to-A transfers behave as in R1 to R4, using the B-to-A strobe, capture enable and output enable, taking b_in and driving a_out/a_drv.
- R7: A strobe, enable or data change in one section leaves the other section's registers and outputs unchanged.
- R8: With HOLD_EN=1 (the default), a released port section with no outside driver shows the last value the block drove on it, even if the register is later loaded with new data.
- R9: With HOLD_EN=1, after an outside agent drives a released section (its *_ext bit is 1) for at least one clock edge and then stops, that section's output shows the last value the agent drove.
- R10: The contention output of a port section is 1 exactly when the block drives that section and its *_ext bit is 1.
- R11: Asserting arst_n low clears all registers and keepers to zero at once. Release is synchronised over two system clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| arst_n | input | 1 | Asynchronous reset, active low |
| ab_clk | input | 2 | A-to-B transfer strobe per section, acts on its rising transition |
| ab_ce_n | input | 2 | A-to-B capture enable per section, active low |
| ab_oe_n | input | 2 | B-port output enable per section, active low |
| ba_clk | input | 2 | B-to-A transfer strobe per section |
| ba_ce_n | input | 2 | B-to-A capture enable per section, active low |
| ba_oe_n | input | 2 | A-port output enable per section, active low |
| a_in | input | 16 | Level present on the A lines |
| a_ext | input | 2 | Outside agent drives this A section |
| a_out | output | 16 | Value the block drives or holds on the A lines |
| a_drv | output | 2 | Block drives this A section |
| a_conflict | output | 2 | Block and outside agent both drive this A section |
| b_in | input | 16 | Level present on the B lines |
| b_ext | input | 2 | Outside agent drives this B section |
| b_out | output | 16 | Value the block drives or holds on the B lines |
| b_drv | output | 2 | Block drives this B section |
| b_conflict | output | 2 | Block and outside agent both drive this B section |

## Verification
The hardest state to reach is a keeper whose held value differs from the register behind it. To get there, a port must be driven long enough for the keeper to follow the register, then released, and then the register must be loaded again while the port stays released. The bench builds exactly this order. It also sets up a second variant, in which an outside agent drives a released section for one edge and then stops. In both variants the bench checks that the held level, not the register, appears on the output.

// File: rtl/dbx_pkg.sv
package dbx_pkg;
  localparam int unsigned SEC_W_DEF    = 8;
  localparam int unsigned SECTIONS_DEF = 2;

  typedef enum logic [1:0] {
    PS_RELEASED = 2'd0,
    PS_EXTERNAL = 2'd1,
    PS_DRIVEN   = 2'd2,
    PS_CONFLICT = 2'd3
  } port_state_e;
endpackage

// File: rtl/dbx_rst_sync.sv
module dbx_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [1:0] shift_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) shift_q <= 2'b00;
    else         shift_q <= {shift_q[0], 1'b1};
  end

  assign rst_n = shift_q[1];
endmodule

// File: rtl/dbx_dir_reg.sv
module dbx_dir_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         strobe,
  input  logic         ce_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic         strobe_q;
  logic         take;
  logic [W-1:0] q_nxt;

  always_comb begin
    take  = strobe & ~strobe_q & ~ce_n;
    q_nxt = take ? d : q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      q        <= '0;
    end else begin
      strobe_q <= strobe;
      q        <= q_nxt;
    end
  end
endmodule

// File: rtl/dbx_port_side.sv
module dbx_port_side
  import dbx_pkg::*;
#(
  parameter int unsigned W       = 8,
  parameter bit          HOLD_EN = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         oe_n,
  input  logic         ext,
  input  logic [W-1:0] din,
  input  logic [W-1:0] q,
  output logic [W-1:0] dout,
  output logic         drv,
  output logic         conflict
);
  port_state_e  state;
  logic [W-1:0] held;

  always_comb begin
    case ({~oe_n, ext})
      2'b11:   state = PS_CONFLICT;
      2'b10:   state = PS_DRIVEN;
      2'b01:   state = PS_EXTERNAL;
      default: state = PS_RELEASED;
    endcase
  end

  generate
    if (HOLD_EN) begin : g_keeper
      logic [W-1:0] keep_q;
      logic [W-1:0] keep_nxt;

      always_comb begin
        case (state)
          PS_DRIVEN, PS_CONFLICT: keep_nxt = q;
          PS_EXTERNAL:            keep_nxt = din;
          default:                keep_nxt = keep_q;
        endcase
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) keep_q <= '0;
        else        keep_q <= keep_nxt;
      end

      assign held = keep_q;
    end else begin : g_float
      logic unused_in;
      assign unused_in = ^{clk, rst_n, din};
      assign held = '0;
    end
  endgenerate

  assign drv      = (state == PS_DRIVEN) || (state == PS_CONFLICT);
  assign conflict = (state == PS_CONFLICT);
  assign dout     = drv ? q : held;
endmodule

// File: rtl/dbx_transceiver.sv
module dbx_transceiver #(
  parameter int unsigned SEC_W    = dbx_pkg::SEC_W_DEF,
  parameter int unsigned SECTIONS = dbx_pkg::SECTIONS_DEF,
  parameter bit          HOLD_EN  = 1'b1,
  localparam int unsigned W       = SEC_W * SECTIONS
) (
  input  logic                clk,
  input  logic                arst_n,
  input  logic [SECTIONS-1:0] ab_clk,
  input  logic [SECTIONS-1:0] ab_ce_n,
  input  logic [SECTIONS-1:0] ab_oe_n,
  input  logic [SECTIONS-1:0] ba_clk,
  input  logic [SECTIONS-1:0] ba_ce_n,
  input  logic [SECTIONS-1:0] ba_oe_n,
  input  logic [W-1:0]        a_in,
  input  logic [SECTIONS-1:0] a_ext,
  output logic [W-1:0]        a_out,
  output logic [SECTIONS-1:0] a_drv,
  output logic [SECTIONS-1:0] a_conflict,
  input  logic [W-1:0]        b_in,
  input  logic [SECTIONS-1:0] b_ext,
  output logic [W-1:0]        b_out,
  output logic [SECTIONS-1:0] b_drv,
  output logic [SECTIONS-1:0] b_conflict
);
  logic         rst_n;
  logic [W-1:0] ab_q;
  logic [W-1:0] ba_q;

  dbx_rst_sync u_rst (.clk(clk), .arst_n(arst_n), .rst_n(rst_n));

  for (genvar s = 0; s < SECTIONS; s++) begin : g_sec
    localparam int unsigned LO = s * SEC_W;

    dbx_dir_reg #(.W(SEC_W)) u_ab_reg (
      .clk(clk), .rst_n(rst_n), .strobe(ab_clk[s]), .ce_n(ab_ce_n[s]),
      .d(a_in[LO +: SEC_W]), .q(ab_q[LO +: SEC_W])
    );

    dbx_dir_reg #(.W(SEC_W)) u_ba_reg (
      .clk(clk), .rst_n(rst_n), .strobe(ba_clk[s]), .ce_n(ba_ce_n[s]),
      .d(b_in[LO +: SEC_W]), .q(ba_q[LO +: SEC_W])
    );

    dbx_port_side #(.W(SEC_W), .HOLD_EN(HOLD_EN)) u_b_side (
      .clk(clk), .rst_n(rst_n), .oe_n(ab_oe_n[s]), .ext(b_ext[s]),
      .din(b_in[LO +: SEC_W]), .q(ab_q[LO +: SEC_W]),
      .dout(b_out[LO +: SEC_W]), .drv(b_drv[s]), .conflict(b_conflict[s])
    );

    dbx_port_side #(.W(SEC_W), .HOLD_EN(HOLD_EN)) u_a_side (
      .clk(clk), .rst_n(rst_n), .oe_n(ba_oe_n[s]), .ext(a_ext[s]),
      .din(a_in[LO +: SEC_W]), .q(ba_q[LO +: SEC_W]),
      .dout(a_out[LO +: SEC_W]), .drv(a_drv[s]), .conflict(a_conflict[s])
    );
  end
endmodule

// File: rtl/dbx_checker.sv
module dbx_checker #(
  parameter int unsigned SEC_W    = 8,
  parameter int unsigned SECTIONS = 2,
  localparam int unsigned W       = SEC_W * SECTIONS
) (
  input logic                clk,
  input logic                rst_n,
  input logic [SECTIONS-1:0] ab_clk,
  input logic [SECTIONS-1:0] ab_ce_n,
  input logic [SECTIONS-1:0] ba_clk,
  input logic [SECTIONS-1:0] ba_ce_n,
  input logic [W-1:0]        a_in,
  input logic [W-1:0]        b_in,
  input logic [W-1:0]        ab_q,
  input logic [W-1:0]        ba_q,
  input logic [W-1:0]        a_out,
  input logic [W-1:0]        b_out,
  input logic [SECTIONS-1:0] a_drv,
  input logic [SECTIONS-1:0] b_drv,
  input logic [SECTIONS-1:0] a_ext,
  input logic [SECTIONS-1:0] b_ext,
  input logic [SECTIONS-1:0] a_conflict,
  input logic [SECTIONS-1:0] b_conflict
);
  logic [SECTIONS-1:0] ab_prev, ba_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ab_prev <= '0;
      ba_prev <= '0;
    end else begin
      ab_prev <= ab_clk;
      ba_prev <= ba_clk;
    end
  end

  for (genvar s = 0; s < SECTIONS; s++) begin : g_chk
    localparam int unsigned LO = s * SEC_W;

    a_r1_capture_ab: assert property (@(posedge clk) disable iff (!rst_n)
      (ab_clk[s] && !ab_prev[s] && !ab_ce_n[s]) |=> (ab_q[LO +: SEC_W] == $past(a_in[LO +: SEC_W])));
    a_r6_capture_ba: assert property (@(posedge clk) disable iff (!rst_n)
      (ba_clk[s] && !ba_prev[s] && !ba_ce_n[s]) |=> (ba_q[LO +: SEC_W] == $past(b_in[LO +: SEC_W])));
    a_r2_hold_ab: assert property (@(posedge clk) disable iff (!rst_n)
      ab_ce_n[s] |=> $stable(ab_q[LO +: SEC_W]));
    a_r2_hold_ba: assert property (@(posedge clk) disable iff (!rst_n)
      ba_ce_n[s] |=> $stable(ba_q[LO +: SEC_W]));
    a_r3_level_ab: assert property (@(posedge clk) disable iff (!rst_n)
      (ab_clk[s] && ab_prev[s]) |=> $stable(ab_q[LO +: SEC_W]));
    a_r4_drive_b: assert property (@(posedge clk) disable iff (!rst_n)
      b_drv[s] |-> (b_out[LO +: SEC_W] == ab_q[LO +: SEC_W]));
    a_r6_drive_a: assert property (@(posedge clk) disable iff (!rst_n)
      a_drv[s] |-> (a_out[LO +: SEC_W] == ba_q[LO +: SEC_W]));
    a_r8_keep_b: assert property (@(posedge clk) disable iff (!rst_n)
      (!b_drv[s] && !b_ext[s]) ##1 (!b_drv[s] && !b_ext[s]) |-> $stable(b_out[LO +: SEC_W]));
    a_r8_keep_a: assert property (@(posedge clk) disable iff (!rst_n)
      (!a_drv[s] && !a_ext[s]) ##1 (!a_drv[s] && !a_ext[s]) |-> $stable(a_out[LO +: SEC_W]));
    a_r10_flag_b: assert property (@(posedge clk) disable iff (!rst_n)
      b_conflict[s] |-> (b_drv[s] && b_ext[s]));
    a_r10_flag_a: assert property (@(posedge clk) disable iff (!rst_n)
      a_conflict[s] |-> (a_drv[s] && a_ext[s]));
  end
endmodule

bind dbx_transceiver dbx_checker #(.SEC_W(SEC_W), .SECTIONS(SECTIONS)) u_chk (
  .clk(clk), .rst_n(rst_n), .ab_clk(ab_clk), .ab_ce_n(ab_ce_n),
  .ba_clk(ba_clk), .ba_ce_n(ba_ce_n), .a_in(a_in), .b_in(b_in),
  .ab_q(ab_q), .ba_q(ba_q), .a_out(a_out), .b_out(b_out),
  .a_drv(a_drv), .b_drv(b_drv), .a_ext(a_ext), .b_ext(b_ext),
  .a_conflict(a_conflict), .b_conflict(b_conflict)
);

// File: tb/tb_dbx_transceiver.sv
module tb_dbx_transceiver;
  logic        clk = 1'b0;
  logic        arst_n;
  logic [1:0]  ab_clk, ab_ce_n, ab_oe_n, ba_clk, ba_ce_n, ba_oe_n;
  logic [15:0] a_in, b_in;
  logic [1:0]  a_ext, b_ext;
  logic [15:0] a_out, b_out;
  logic [1:0]  a_drv, b_drv, a_conflict, b_conflict;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  dbx_transceiver dut (
    .clk(clk), .arst_n(arst_n),
    .ab_clk(ab_clk), .ab_ce_n(ab_ce_n), .ab_oe_n(ab_oe_n),
    .ba_clk(ba_clk), .ba_ce_n(ba_ce_n), .ba_oe_n(ba_oe_n),
    .a_in(a_in), .a_ext(a_ext), .a_out(a_out), .a_drv(a_drv), .a_conflict(a_conflict),
    .b_in(b_in), .b_ext(b_ext), .b_out(b_out), .b_drv(b_drv), .b_conflict(b_conflict)
  );

  // {ce_n, data, expected B register of section 0}
  localparam logic [16:0] VEC [8] = '{
    {1'b0, 8'h3C, 8'h3C}, {1'b1, 8'hFF, 8'h3C}, {1'b0, 8'hA5, 8'hA5},
    {1'b1, 8'h00, 8'hA5}, {1'b0, 8'h00, 8'h00}, {1'b0, 8'hFF, 8'hFF},
    {1'b1, 8'h12, 8'hFF}, {1'b0, 8'h81, 8'h81}
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse_ab(input int s);
    ab_clk[s] = 1'b1; tick();
    ab_clk[s] = 1'b0; tick();
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    arst_n = 1'b0;
    ab_clk = '0; ba_clk = '0; ab_ce_n = '1; ba_ce_n = '1;
    ab_oe_n = '0; ba_oe_n = '0; a_in = '0; b_in = '0; a_ext = '0; b_ext = '0;
    repeat (3) tick();
    arst_n = 1'b1;
    repeat (3) tick();

    // R11: reset leaves zero on both driven ports
    chk("R11 b_out after reset", b_out, 16'h0000);
    chk("R11 a_out after reset", a_out, 16'h0000);
    // R4: drive enable follows output enable
    chk("R4 b_drv with oe_n=00", {14'd0, b_drv}, 16'h0003);

    // R1/R2: table walk on section 0 A-to-B
    for (int i = 0; i < 8; i++) begin
      ab_ce_n[0] = VEC[i][16];
      a_in[7:0]  = VEC[i][15:8];
      pulse_ab(0);
      chk(VEC[i][16] ? "R2 hold with ce_n=1" : "R1 capture with ce_n=0",
          {8'h00, b_out[7:0]}, {8'h00, VEC[i][7:0]});
    end

    // R3: level-held strobe captures only once
    ab_ce_n[0] = 1'b0; a_in[7:0] = 8'h11;
    ab_clk[0] = 1'b1; tick();
    a_in[7:0] = 8'h22; tick(); tick();
    chk("R3 held strobe", {8'h00, b_out[7:0]}, 16'h0011);
    ab_clk[0] = 1'b0; tick();

    // R4: released port stops driving
    ab_oe_n[0] = 1'b1; #1;
    chk("R4 b_drv released", {14'd0, b_drv}, 16'h0002);

    // R8: released port holds last driven value while register reloads
    a_in[7:0] = 8'h5A; pulse_ab(0);
    chk("R8 keeper hides new register", {8'h00, b_out[7:0]}, 16'h0011);
    // R5: capture while released appears once enabled
    ab_oe_n[0] = 1'b0; #1;
    chk("R5 capture while released", {8'h00, b_out[7:0]}, 16'h005A);
    tick();

    // R9: outside agent drives released B section 0 then stops
    ab_oe_n[0] = 1'b1; b_ext[0] = 1'b1; b_in[7:0] = 8'h77; tick();
    b_ext[0] = 1'b0; b_in[7:0] = 8'h00; #1;
    chk("R9 keeper takes external level", {8'h00, b_out[7:0]}, 16'h0077);

    // R10: contention flag
    chk("R10 no contention", {12'd0, a_conflict, b_conflict}, 16'h0000);
    ab_oe_n[0] = 1'b0; b_ext[0] = 1'b1; #1;
    chk("R10 contention B0", {12'd0, a_conflict, b_conflict}, 16'h0001);
    b_ext[0] = 1'b0; tick();

    // R6: B-to-A on section 1
    ba_ce_n[1] = 1'b0; b_in[15:8] = 8'hC3;
    ba_clk[1] = 1'b1; tick(); ba_clk[1] = 1'b0; tick();
    chk("R6 B-to-A capture section 1", a_out, 16'hC300);
    ba_oe_n[1] = 1'b1; #1;
    chk("R6 a_drv follows ba_oe_n", {14'd0, a_drv}, 16'h0001);

    // R7: section 1 A-to-B strobe leaves section 0 untouched
    ab_ce_n[1] = 1'b0; a_in = 16'h9E44; pulse_ab(1);
    chk("R7 section independence", b_out, 16'h9E5A);

    // R11: asynchronous clear
    arst_n = 1'b0; #1;
    chk("R11 async clear b_out", b_out, 16'h0000);
    arst_n = 1'b1; repeat (3) tick();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule